// File: doc/BRIEF.md
# Fractional PLL Output Frequency Calculator

This block turns the programmed divider fields of a fractional-N PLL and its reference frequency into the PLL's output frequency in Hz. The caller presents the reference rate, the integer multiplier, the fractional numerator and denominator, the reference-divider code, the output-divider code and a mode bit. It then pulses `start`. Some cycles later the block returns the integer frequency with a one-cycle `done` pulse.

The raw divider codes are first turned into real divisors. A reference-divider code of zero divides by one. Output-divider codes zero and one divide by two and three. The multiplier term and the denominator are then formed. A shift-add multiplier builds the wide numerator. A restoring divider, which takes one quotient bit per cycle, then divides it. In fractional mode the ratio numerator/denominator is folded into a single division, so no fraction is lost before the final truncation.

Top module: `pll_rate_calc`

## Requirements
- R1: A reference-divider code of 0 acts as divide-by-1. Every other code N divides by N.
- R2: Output-divider code 0 divides by 2 and code 1 divides by 3. Every other code N divides by N.
- R3: With `frac_mode`=0 the result is floor(ref × MFI / (rdiv × odiv)). The `mfn` and `mfd` inputs have no effect, and a zero `mfd` raises no error.
- R4: With `frac_mode`=1 and `mfd`≠0 the result is floor((ref × MFI × MFD + ref × MFN) / (MFD × rdiv × odiv)), truncated toward zero.
- R5: With `frac_mode`=1 and `mfd`=0, an accepted start gives `done` with `err`=1 and `rate_hz`=0 in the next cycle, and `busy` stays low.
- R6: An accepted valid start raises `busy` in the next cycle. `busy` falls in the cycle where `done` rises, and that happens exactly 136 cycles after the accepting edge (40 multiply steps plus 96 divide steps). `done` lasts one cycle.
- R7: `busy` and `done` are never high together.
- R8: A `start` that arrives while `busy` is high is ignored. The result returned is that of the calculation already running.
- R9: The synchronous active-high `rst` clears `busy`, `done`, `err` and `rate_hz`, even in the middle of a calculation.
- R10: `rate_hz` and `err` hold their values from one `done` until the next. A successful calculation clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, taken only while idle |
| frac_mode | input | 1 | 1 = fractional formula, 0 = integer formula |
| ref_hz | input | 32 | Reference frequency in Hz |
| mfi | input | 9 | Integer multiplier |
| mfn | input | 30 | Fractional numerator |
| mfd | input | 30 | Fractional denominator |
| rdiv_code | input | 3 | Reference-divider field code |
| odiv_code | input | 8 | Output-divider field code |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completion was a zero-denominator fault |
| rate_hz | output | 72 | Computed output frequency in Hz |

## Verification
The bench sweeps all eight reference-divider codes against the special output-divider codes 0, 1 and 2 and a few ordinary ones. A decoder that took codes literally would return results two or three times too large, or would divide by zero. Operands at full width, such as a reference of all ones with numerator and denominator near 2^30, expose a numerator or accumulator that is too narrow: the result comes back wrapped. Integer-mode runs with a zero or garbage denominator show whether fractional terms leak into the wrong formula. Starts issued while busy, a reset in mid-run and repeated zero-denominator requests show whether operands can be overwritten, state survives reset, or the error path stalls.

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int REF_W  = 32,
  parameter int MFI_W  = 9,
  parameter int MFN_W  = 30,
  parameter int MFD_W  = 30,
  parameter int RDIV_W = 3,
  parameter int ODIV_W = 8,
  parameter int ACC_W  = 96
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic                              frac_mode,
  input  logic [REF_W-1:0]                  ref_hz,
  input  logic [MFI_W-1:0]                  mfi,
  input  logic [MFN_W-1:0]                  mfn,
  input  logic [MFD_W-1:0]                  mfd,
  input  logic [RDIV_W-1:0]                 rdiv_code,
  input  logic [ODIV_W-1:0]                 odiv_code,
  output logic                              busy,
  output logic                              done,
  output logic                              err,
  output logic [REF_W+MFI_W+MFD_W+1-1:0]    rate_hz
);
  localparam int FACT_W = MFI_W + MFD_W + 1;
  localparam int NUM_W  = REF_W + FACT_W;
  localparam int DEN_W  = MFD_W + RDIV_W + ODIV_W;
  localparam int RES_W  = NUM_W;
  localparam int CNT_W  = $clog2(ACC_W > FACT_W ? ACC_W : FACT_W);

  typedef enum logic {PH_MUL, PH_DIV} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_W-1:0]  mcand;
  logic [FACT_W-1:0] mplier;
  logic [ACC_W-1:0]  acc;
  logic [DEN_W-1:0]  rem;
  logic [DEN_W-1:0]  den;

  logic [RDIV_W-1:0] rdiv_eff;
  logic [ODIV_W-1:0] odiv_eff;
  logic [FACT_W-1:0] fact_in;
  logic [DEN_W-1:0]  den_in;
  logic              accept, bad;

  assign rdiv_eff = (rdiv_code == '0) ? RDIV_W'(1) : rdiv_code;
  assign odiv_eff = (odiv_code == ODIV_W'(0)) ? ODIV_W'(2) :
                    (odiv_code == ODIV_W'(1)) ? ODIV_W'(3) : odiv_code;

  assign fact_in = frac_mode ? FACT_W'(mfi) * FACT_W'(mfd) + FACT_W'(mfn)
                             : FACT_W'(mfi);
  assign den_in  = (frac_mode ? DEN_W'(mfd) : DEN_W'(1)) * DEN_W'(rdiv_eff) * DEN_W'(odiv_eff);

  assign accept = start && !busy;
  assign bad    = frac_mode && (mfd == '0);

  logic [ACC_W-1:0]  acc_add;
  logic [DEN_W:0]    trial, rem_nx;
  logic              ge;
  logic [ACC_W-1:0]  quo_nx;

  assign acc_add = acc + (mplier[0] ? ACC_W'(mcand) : '0);
  assign trial   = {rem, acc[ACC_W-1]};
  assign ge      = trial >= {1'b0, den};
  assign rem_nx  = ge ? trial - {1'b0, den} : trial;
  assign quo_nx  = {acc[ACC_W-2:0], ge};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rate_hz <= '0;
      phase   <= PH_MUL;
      cnt     <= '0;
      mcand   <= '0;
      mplier  <= '0;
      acc     <= '0;
      rem     <= '0;
      den     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (bad) begin
          done    <= 1'b1;
          err     <= 1'b1;
          rate_hz <= '0;
        end else begin
          busy   <= 1'b1;
          phase  <= PH_MUL;
          cnt    <= '0;
          mcand  <= NUM_W'(ref_hz);
          mplier <= fact_in;
          acc    <= '0;
          rem    <= '0;
          den    <= den_in;
        end
      end else if (busy) begin
        if (phase == PH_MUL) begin
          acc    <= acc_add;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          if (cnt == CNT_W'(FACT_W - 1)) begin
            phase <= PH_DIV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          rem <= rem_nx[DEN_W-1:0];
          acc <= quo_nx;
          if (cnt == CNT_W'(ACC_W - 1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            err     <= 1'b0;
            rate_hz <= quo_nx[RES_W-1:0];
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r4_rem_below_den: assert property (@(posedge clk) disable iff (rst)
    (busy && phase == PH_DIV) |-> (rem < den));

  a_r5_zero_mfd_fault: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && frac_mode && mfd == '0) |=> (done && err && rate_hz == '0 && !busy));

  a_r6_fall_with_done: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> done);

  a_r7_busy_done_apart: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  a_r8_operands_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(den));

  a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !done) |-> ($stable(rate_hz) && $stable(err)));
endmodule

// File: tb/sim_pll_rate_calc.sv
`timescale 1ns/1ps
module sim_pll_rate_calc;
  localparam int RES_W = 72;
  localparam int LAT   = 136;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic frac_mode = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [8:0]  mfi = '0;
  logic [29:0] mfn = '0;
  logic [29:0] mfd = '0;
  logic [2:0]  rdiv_code = '0;
  logic [7:0]  odiv_code = '0;
  logic busy, done, err;
  logic [RES_W-1:0] rate_hz;

  int n_tot = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pll_rate_calc u0 (
    .clk(clk), .rst(rst), .start(start), .frac_mode(frac_mode),
    .ref_hz(ref_hz), .mfi(mfi), .mfn(mfn), .mfd(mfd),
    .rdiv_code(rdiv_code), .odiv_code(odiv_code),
    .busy(busy), .done(done), .err(err), .rate_hz(rate_hz)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expect_rate(input logic fm, input logic [31:0] r,
      input logic [8:0] i, input logic [29:0] n, input logic [29:0] d,
      input logic [2:0] rc, input logic [7:0] oc);
    logic [127:0] rd, od, num, dv;
    rd = (rc == 0) ? 128'd1 : 128'(rc);
    od = (oc == 0) ? 128'd2 : (oc == 1) ? 128'd3 : 128'(oc);
    if (!fm) begin
      num = 128'(r) * 128'(i);
      dv  = rd * od;
    end else begin
      num = 128'(r) * 128'(i) * 128'(d) + 128'(r) * 128'(n);
      dv  = 128'(d) * rd * od;
    end
    return num / dv;
  endfunction

  task automatic launch(input logic fm, input logic [31:0] r, input logic [8:0] i,
      input logic [29:0] n, input logic [29:0] d, input logic [2:0] rc, input logic [7:0] oc);
    frac_mode = fm; ref_hz = r; mfi = i; mfn = n; mfd = d; rdiv_code = rc; odiv_code = oc;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_one(input logic fm, input logic [31:0] r, input logic [8:0] i,
      input logic [29:0] n, input logic [29:0] d, input logic [2:0] rc, input logic [7:0] oc);
    int lat;
    logic [127:0] exp_v;
    exp_v = expect_rate(fm, r, i, n, d, rc, oc);
    launch(fm, r, i, n, d, rc, oc);
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    wait_done(lat);
    check(lat == LAT, "R6 latency", lat, LAT);
    check(128'(rate_hz) == exp_v, fm ? "R4 R1 R2 frac result" : "R3 R1 R2 int result", rate_hz, exp_v);
    check(err == 1'b0, "R10 err clear on success", err, 0);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  logic [31:0] refs [3];
  logic [8:0]  mfis [3];
  logic [29:0] mfns [3];
  logic [29:0] mfds [3];
  logic [7:0]  ods  [5];

  initial begin
    #(20 * 200000);
    n_tot++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    int lat;
    logic [RES_W-1:0] held;
    refs[0] = 32'd24000000;  mfis[0] = 9'd173; mfns[0] = 30'd25;        mfds[0] = 30'd100;
    refs[1] = 32'hFFFFFFFF;  mfis[1] = 9'd511; mfns[1] = 30'h3FFFFFFF; mfds[1] = 30'h3FFFFFFE;
    refs[2] = 32'd19200001;  mfis[2] = 9'd1;   mfns[2] = 30'd7;         mfds[2] = 30'd3;
    ods[0] = 8'd0; ods[1] = 8'd1; ods[2] = 8'd2; ods[3] = 8'd7; ods[4] = 8'd255;

    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !err && rate_hz == 0, "R9 reset state", {busy, done, err}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R4 sweep
    for (int s = 0; s < 3; s++)
      for (int rc = 0; rc < 8; rc++)
        for (int oi = 0; oi < 5; oi++)
          for (int fm = 0; fm < 2; fm++)
            run_one(fm[0], refs[s], mfis[s], mfns[s], mfds[s], rc[2:0], ods[oi]);

    // R3 integer mode ignores a zero or odd denominator and numerator
    run_one(1'b0, 32'd24000000, 9'd200, 30'd0, 30'd0, 3'd1, 8'd6);
    run_one(1'b0, 32'd24000000, 9'd200, 30'h3FFFFFFF, 30'd5, 3'd1, 8'd6);

    // R5 zero denominator in fractional mode, twice back to back
    launch(1'b1, 32'd24000000, 9'd100, 30'd9, 30'd0, 3'd2, 8'd4);
    check(done && err && rate_hz == 0 && !busy, "R5 zero mfd fault", {done, err, busy}, 3'b110);
    launch(1'b1, 32'd24000000, 9'd100, 30'd9, 30'd0, 3'd2, 8'd4);
    check(done && err, "R5 repeat fault", {done, err}, 2'b11);
    @(negedge clk);
    // R10 err held after fault
    check(err == 1'b1 && rate_hz == 0, "R10 err held", err, 1);

    // R8 start while busy ignored
    launch(1'b0, 32'd24000000, 9'd150, 30'd0, 30'd1, 3'd1, 8'd4);
    repeat (10) @(negedge clk);
    frac_mode = 1'b1; ref_hz = 32'd1000; mfi = 9'd3; mfd = 30'd0; odiv_code = 8'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && busy == 1'b1, "R8 start ignored while busy", {done, busy}, 2'b01);
    wait_done(lat);
    check(rate_hz == 72'd900000000 && err == 1'b0, "R8 first result kept", rate_hz, 900000000);
    check(lat == LAT - 11, "R8 R6 latency unaffected", lat, LAT - 11);
    held = rate_hz;
    repeat (5) @(negedge clk);
    check(rate_hz == held && !done, "R10 result held", rate_hz, held);

    // R9 reset mid calculation
    launch(1'b1, 32'd24000000, 9'd173, 30'd25, 30'd100, 3'd1, 8'd4);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && rate_hz == 0, "R9 reset mid run", {busy, done, err}, 0);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    check(!busy && !done, "R9 stays idle after reset", {busy, done}, 0);

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule